// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block holds the hazard control for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each cycle it takes the register numbers and control flags held in the pipeline registers, plus the branch outcome from the memory stage. From these it decides whether the front end must hold, whether the execute stage gets an empty slot, whether the three youngest instructions must be squashed, and which source feeds each ALU operand.

Branches are predicted not taken, so fetch runs on in sequence. The branch outcome is only known once the branch reaches the memory stage. A taken outcome there squashes everything younger.

The build-time parameter `FWD_EN` selects one of two variants:
- **With forwarding:** results are bypassed from the memory and writeback pipeline registers. Only a load followed at once by a consumer costs a cycle.
- **Without forwarding:** every read-after-write dependency holds the consumer in decode until its producer reaches writeback. The register file writes early in the cycle and reads late, so that distance needs no wait.

Top module: `hazard_ctrl`

## Requirements
- R1: `kill_ifid`, `kill_idex` and `kill_exmem` are all 1 in the same cycle that `mem_branch` and `mem_taken` are both 1. In every other cycle they are 0, including when `mem_taken` is 1 without `mem_branch`.
- R2: When a taken branch is in the memory stage, `hold_front` and `bubble_idex` are 0, even if a dependency would otherwise stall.
- R3: With `FWD_EN`=0, a decode source that is in use and matches the nonzero `ex_rd` (with `ex_wen`=1) or the nonzero `mem_rd` (with `mem_wen`=1) drives `hold_front` and `bubble_idex` to 1.
- R4: A producer in writeback (`wb_rd`, `wb_wen`) never causes a stall in either variant.
- R5: With `FWD_EN`=1, a stall happens only when the execute stage holds a load (`ex_load`=1, `ex_wen`=1) whose nonzero `ex_rd` matches an in-use decode source. A non-load producer in execute, or any producer in memory, causes no stall.
- R6: With `FWD_EN`=1, each operand select (`fwd_a` for `ex_rs1`, `fwd_b` for `ex_rs2`) uses this encoding:
  - 2'b10 when the memory-stage write matches;
  - otherwise 2'b01 when the writeback write matches;
  - otherwise 2'b00 (register file).

  The memory stage wins when both match, and a write only matches when its write enable is 1.
- R7: Register 0 is never a dependency. A destination or source of 0 triggers neither a stall nor a forward.
- R8: A decode source whose use flag (`id_use_rs1` / `id_use_rs2`) is 0 causes no stall.
- R9: With `FWD_EN`=0, `fwd_a` and `fwd_b` are always 2'b00.
- R10: `hold_front` and `bubble_idex` are always equal. In the replayed load/increment/store/pointer-step/subtract/branch loop, run for two passes with the first branch taken, there are 2 stall cycles with forwarding, 16 without, and one flush cycle in each variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks only |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | AW | First source register held in ID/EX |
| ex_rs2 | input | AW | Second source register held in ID/EX |
| ex_rd | input | AW | Destination register held in ID/EX |
| ex_wen | input | 1 | ID/EX instruction writes a register |
| ex_load | input | 1 | ID/EX instruction is a load |
| mem_rd | input | AW | Destination register held in EX/MEM |
| mem_wen | input | 1 | EX/MEM instruction writes a register |
| wb_rd | input | AW | Destination register held in MEM/WB |
| wb_wen | input | 1 | MEM/WB instruction writes a register |
| mem_branch | input | 1 | EX/MEM instruction is a conditional branch |
| mem_taken | input | 1 | Branch condition evaluated true in the memory stage |
| hold_front | output | 1 | Freeze the PC and the IF/ID register |
| bubble_idex | output | 1 | Load a no-op into ID/EX |
| kill_ifid | output | 1 | Replace the IF/ID contents with a no-op |
| kill_idex | output | 1 | Replace the ID/EX contents with a no-op |
| kill_exmem | output | 1 | Replace the EX/MEM contents with a no-op |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |

## Verification
The block has no state, so any fault shows at the ports in the very cycle the bad inputs arrive.

A missed dependency shows as `hold_front` staying low while a matching producer sits in execute or memory. A spurious one shows as a hold with no match, or with register 0 as the match.

Across a whole loop replay, either fault moves the total stall count away from 2 or 16. A broken redirect shows as a flush count other than one, or as a hold in the flush cycle.

A wrong priority between bypass paths shows as select 2'b01 where 2'b10 is due.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_REG = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic hold;
        logic bubble;
        logic kill_ifid;
        logic kill_idex;
        logic kill_exmem;
    } flow_ctl_t;

endpackage

// File: rtl/hz_dep_detect.sv
module hz_dep_detect #(
    parameter int AW     = 5,
    parameter bit FWD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src,
    input  logic          id_use,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    output logic          hazard
);

    logic live_src;
    logic ex_match;
    logic mem_match;

    always_comb begin
        live_src  = id_use && (id_src != '0);
        ex_match  = live_src && ex_wen && (ex_rd == id_src);
        mem_match = live_src && mem_wen && (mem_rd == id_src);
    end

    generate
        if (FWD_EN) begin : g_bypass
            // only a load still in execute cannot be bypassed in time
            assign hazard = ex_match && ex_load;
        end else begin : g_wait_wb
            // consumer waits until the producer reaches writeback
            assign hazard = ex_match || mem_match;
        end
    endgenerate

    AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_use && id_src != '0 && ex_load && ex_wen && ex_rd == id_src) |-> hazard); // R5

endmodule

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int AW     = 5,
    parameter bit FWD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);

    generate
        if (FWD_EN) begin : g_full
            logic mem_hit;
            logic wb_hit;
            always_comb begin
                mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
                wb_hit  = wb_wen && (wb_rd != '0) && (wb_rd == src);
                if (mem_hit)     sel = FWD_MEM;
                else if (wb_hit) sel = FWD_WB;
                else             sel = FWD_REG;
            end

            AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_wen && src != '0 && mem_rd == src) |-> (sel == FWD_MEM)); // R6
        end else begin : g_none
            assign sel = FWD_REG;
        end
    endgenerate

endmodule

// File: rtl/hz_flow_ctl.sv
module hz_flow_ctl
    import hz_pkg::*;
(
    input  logic      hazard,
    input  logic      mem_branch,
    input  logic      mem_taken,
    output flow_ctl_t ctl
);

    flow_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        if (mem_branch && mem_taken) begin
            // redirect squashes the three younger slots; they may not hold
            ctl_d.kill_ifid  = 1'b1;
            ctl_d.kill_idex  = 1'b1;
            ctl_d.kill_exmem = 1'b1;
        end else if (hazard) begin
            ctl_d.hold   = 1'b1;
            ctl_d.bubble = 1'b1;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int AW     = 5,
    parameter bit FWD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    input  logic          mem_branch,
    input  logic          mem_taken,
    output logic          hold_front,
    output logic          bubble_idex,
    output logic          kill_ifid,
    output logic          kill_idex,
    output logic          kill_exmem,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b
);

    localparam int NOPS = 2;

    logic [AW-1:0] id_src [NOPS];
    logic          id_use [NOPS];
    logic [AW-1:0] ex_src [NOPS];
    logic          haz    [NOPS];
    fwd_sel_e      sel    [NOPS];
    logic          any_hazard;
    flow_ctl_t     ctl;

    always_comb begin
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
        id_use[0] = id_use_rs1;
        id_use[1] = id_use_rs2;
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_op
            hz_dep_detect #(.AW(AW), .FWD_EN(FWD_EN)) u_dep (
                .clk     (clk),
                .rst_n   (rst_n),
                .id_src  (id_src[k]),
                .id_use  (id_use[k]),
                .ex_rd   (ex_rd),
                .ex_wen  (ex_wen),
                .ex_load (ex_load),
                .mem_rd  (mem_rd),
                .mem_wen (mem_wen),
                .hazard  (haz[k])
            );
            hz_operand_fwd #(.AW(AW), .FWD_EN(FWD_EN)) u_fwd (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (ex_src[k]),
                .mem_rd  (mem_rd),
                .mem_wen (mem_wen),
                .wb_rd   (wb_rd),
                .wb_wen  (wb_wen),
                .sel     (sel[k])
            );
        end
    endgenerate

    assign any_hazard = haz[0] || haz[1];

    hz_flow_ctl u_flow (
        .hazard     (any_hazard),
        .mem_branch (mem_branch),
        .mem_taken  (mem_taken),
        .ctl        (ctl)
    );

    assign hold_front  = ctl.hold;
    assign bubble_idex = ctl.bubble;
    assign kill_ifid   = ctl.kill_ifid;
    assign kill_idex   = ctl.kill_idex;
    assign kill_exmem  = ctl.kill_exmem;
    assign fwd_a       = sel[0];
    assign fwd_b       = sel[1];

    AST_REDIRECT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_branch && mem_taken) |-> (kill_ifid && kill_idex && kill_exmem)); // R1
    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_branch && mem_taken) |-> (!hold_front && !bubble_idex)); // R2
    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (fwd_a == FWD_REG)); // R7
    AST_NO_KILL_WITHOUT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_branch |-> !kill_exmem); // R1

endmodule

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;

    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use_rs1, id_use_rs2, ex_wen, ex_load, mem_wen, wb_wen, mem_branch, mem_taken;
    logic h0, b0, k0a, k0b, k0c, h1, b1, k1a, k1b, k1c;
    logic [1:0] fa0, fb0, fa1, fb1;

    int checks = 0;
    int fails  = 0;

    hazard_ctrl #(.AW(AW), .FWD_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .mem_branch(mem_branch), .mem_taken(mem_taken),
        .hold_front(h0), .bubble_idex(b0), .kill_ifid(k0a), .kill_idex(k0b), .kill_exmem(k0c),
        .fwd_a(fa0), .fwd_b(fb0));

    hazard_ctrl #(.AW(AW), .FWD_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .mem_branch(mem_branch), .mem_taken(mem_taken),
        .hold_front(h1), .bubble_idex(b1), .kill_ifid(k1a), .kill_idex(k1b), .kill_exmem(k1c),
        .fwd_a(fa1), .fwd_b(fb1));

    // one vector: inputs, then expected (fwd variant), then expected (no-fwd variant)
    typedef struct packed {
        logic [4:0] i1; logic [4:0] i2; logic u1; logic u2;
        logic [4:0] e1; logic [4:0] e2; logic [4:0] erd; logic ew; logic el;
        logic [4:0] mrd; logic mw; logic [4:0] wrd; logic ww; logic br; logic tk;
        logic fh; logic fk; logic [1:0] fa; logic [1:0] fb;
        logic nh; logic nk; logic [1:0] na; logic [1:0] nb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R10 idle
        '{5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R3 R5 ALU producer in EX
        '{5'd3,5'd0,1'b1,1'b0, 5'd0,5'd0,5'd3,1'b1,1'b0, 5'd0,1'b0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b1,1'b0,2'd0,2'd0},
        // R3 R5 producer in MEM, second source
        '{5'd0,5'd4,1'b0,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd4,1'b1,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b1,1'b0,2'd0,2'd0},
        // R4 producer in WB
        '{5'd5,5'd0,1'b1,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd5,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R5 load-use
        '{5'd6,5'd0,1'b1,1'b0, 5'd0,5'd0,5'd6,1'b1,1'b1, 5'd0,1'b0,5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd0,2'd0, 1'b1,1'b0,2'd0,2'd0},
        // R8 source not used
        '{5'd6,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd6,1'b1,1'b1, 5'd0,1'b0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R7 register zero
        '{5'd0,5'd0,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,5'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R6 R9 MEM beats WB
        '{5'd0,5'd0,1'b0,1'b0, 5'd7,5'd0,5'd0,1'b0,1'b0, 5'd7,1'b1,5'd7,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd2,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R6 R9 WB on B, MEM elsewhere
        '{5'd0,5'd0,1'b0,1'b0, 5'd7,5'd8,5'd0,1'b0,1'b0, 5'd9,1'b1,5'd8,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd1, 1'b0,1'b0,2'd0,2'd0},
        // R6 MEM match without write enable falls back to WB
        '{5'd0,5'd0,1'b0,1'b0, 5'd0,5'd9,5'd0,1'b0,1'b0, 5'd9,1'b0,5'd9,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd1, 1'b0,1'b0,2'd0,2'd0},
        // R1 taken branch
        '{5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,1'b1,1'b1, 1'b0,1'b1,2'd0,2'd0, 1'b0,1'b1,2'd0,2'd0},
        // R1 not-taken branch
        '{5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0},
        // R2 flush with pending load-use
        '{5'd3,5'd0,1'b1,1'b0, 5'd0,5'd0,5'd3,1'b1,1'b1, 5'd0,1'b0,5'd0,1'b0,1'b1,1'b1, 1'b0,1'b1,2'd0,2'd0, 1'b0,1'b1,2'd0,2'd0},
        // R1 taken flag without a branch
        '{5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0,2'd0, 1'b0,1'b0,2'd0,2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t v);
        id_rs1 = v.i1; id_rs2 = v.i2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
        ex_rs1 = v.e1; ex_rs2 = v.e2; ex_rd = v.erd; ex_wen = v.ew; ex_load = v.el;
        mem_rd = v.mrd; mem_wen = v.mw; wb_rd = v.wrd; wb_wen = v.ww;
        mem_branch = v.br; mem_taken = v.tk;
    endtask

    // replay model
    typedef struct packed {
        logic [4:0] rd; logic [4:0] s1; logic [4:0] s2;
        logic u1; logic u2; logic wen; logic ld; logic br;
    } ins_t;

    function automatic ins_t prog(input int pc);
        ins_t n = '0;
        case (pc)
            0: n = '{5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}; // load r1,(r2)
            1: n = '{5'd1, 5'd1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}; // r1 += 1
            2: n = '{5'd0, 5'd2, 5'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}; // store r1,(r2)
            3: n = '{5'd2, 5'd2, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}; // r2 += 4
            4: n = '{5'd4, 5'd3, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}; // r4 = r3 - r2
            5: n = '{5'd0, 5'd4, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}; // branch if r4 != 0
            default: n = '0;
        endcase
        return n;
    endfunction

    task automatic run_loop(input bit fwd, input int exp_stall, input int exp_flush, input string tag);
        ins_t s_id = '0, s_ex = '0, s_mem = '0, s_wb = '0;
        int pc = 0;
        int branches = 0;
        int stalls = 0;
        int flushes = 0;
        logic h, k;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            id_rs1 = s_id.s1; id_rs2 = s_id.s2; id_use_rs1 = s_id.u1; id_use_rs2 = s_id.u2;
            ex_rs1 = s_ex.s1; ex_rs2 = s_ex.s2; ex_rd = s_ex.rd; ex_wen = s_ex.wen; ex_load = s_ex.ld;
            mem_rd = s_mem.rd; mem_wen = s_mem.wen; wb_rd = s_wb.rd; wb_wen = s_wb.wen;
            mem_branch = s_mem.br; mem_taken = s_mem.br && (branches == 0);
            #1;
            h = fwd ? h0 : h1;
            k = fwd ? k0c : k1c;
            if (s_mem.br) branches++;
            s_wb = s_mem;
            if (k) begin
                flushes++;
                s_mem = '0; s_ex = '0; s_id = '0; pc = 0;
            end else if (h) begin
                stalls++;
                s_mem = s_ex; s_ex = '0;
            end else begin
                s_mem = s_ex; s_ex = s_id; s_id = prog(pc); pc++;
            end
        end
        chk({tag, " stall cycles"}, stalls, exp_stall);
        chk({tag, " flush cycles"}, flushes, exp_flush);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        drive_vec('0);
        repeat (3) @(negedge clk);
        // reset state: idle inputs give quiet outputs (R10, R1)
        chk("R10 reset hold", int'(h0), 0);
        chk("R1 reset kill", int'(k1a), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive_vec(VECS[i]);
            #1;
            chk($sformatf("vec%0d R3/R5 hold fwd", i), int'(h0), int'(VECS[i].fh));
            chk($sformatf("vec%0d R10 bubble fwd", i), int'(b0), int'(VECS[i].fh));
            chk($sformatf("vec%0d R1 kill fwd", i), int'({k0a, k0b, k0c}), VECS[i].fk ? 7 : 0);
            chk($sformatf("vec%0d R6 fwd_a", i), int'(fa0), int'(VECS[i].fa));
            chk($sformatf("vec%0d R6 fwd_b", i), int'(fb0), int'(VECS[i].fb));
            chk($sformatf("vec%0d R3 hold nofwd", i), int'(h1), int'(VECS[i].nh));
            chk($sformatf("vec%0d R10 bubble nofwd", i), int'(b1), int'(VECS[i].nh));
            chk($sformatf("vec%0d R1 kill nofwd", i), int'({k1a, k1b, k1c}), VECS[i].nk ? 7 : 0);
            chk($sformatf("vec%0d R9 sel nofwd", i), int'({fa1, fb1}), int'({VECS[i].na, VECS[i].nb}));
        end

        // directed: register zero destination with second source in use (R7)
        @(negedge clk);
        drive_vec('0);
        id_rs2 = 5'd0; id_use_rs2 = 1'b1; mem_rd = 5'd0; mem_wen = 1'b1;
        #1;
        chk("R7 zero dest nofwd", int'(h1), 0);

        // loop replay in both variants (R10, R5, R3, R2)
        run_loop(1'b1, 2, 1, "R10 fwd loop");
        run_loop(1'b0, 16, 1, "R10 nofwd loop");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule